// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a multiplying digital-to-analog converter. It captures a 10-bit converter code from a processor bus into an input latch. It then moves the code into a second register, the DAC register, which drives the converter ladder. Control is through active-low strobes: chip select, write and transfer. A byte-select input picks between a full-word load and a second-byte load.

The input latch has two sections: an 8-bit upper section and a 2-bit lower section. A wide bus loads all ten bits in one write with byte-select high. An 8-bit bus carries a left-justified word in two writes. The first write, with byte-select high, carries the upper byte. The second write, with byte-select low, rewrites only the two lower bits, which it takes from the top lane of the byte.

A transfer is accepted only while byte-select is low. When write and transfer are active in the same cycle, the freshly written bits pass straight into the DAC register. This gives an automatic transfer on the second byte, and flow-through operation when every strobe is held active. Holding transfer back lets many such blocks stage their next code and then switch together on one shared transfer strobe. The strobes act on level and are sampled on the system clock. A one-cycle pulse marks each change of the DAC code.

Top module: `dac_dbuf_front`

## Requirements
- R1: Strobes act on level. On every clock edge where a write is enabled, the input latch loads from `data_i`. On every other edge it holds its value, whatever `data_i` does.
- R2: A write needs `cs_ni` low and `wr_ni` low. While `cs_ni` is high, the input latch holds its value whatever the state of `wr_ni`.
- R3: A write with `byte_hi_i` high loads all ten bits. The upper section takes `data_i[9:2]` and the lower section takes `data_i[1:0]`.
- R4: A write with `byte_hi_i` low loads only the lower section, from `data_i[9:8]`. This is the top two bits of an 8-bit byte placed on `data_i[9:2]`. The upper section keeps its value.
- R5: The DAC register loads from the input latch on a clock edge only when `xfer_ni` is low and `byte_hi_i` is low. Otherwise `code_o` holds its value.
- R6: When a write and a transfer are both enabled in the same cycle, `code_o` takes the word that includes the bits written in that cycle. The new value is visible after that clock edge.
- R7: `rst_ni` low clears the input latch and `code_o` to zero at once, and drives `upd_o` low.
- R8: `upd_o` is high for exactly the one cycle in which `code_o` first shows a new value. It stays low after a transfer that leaves the value unchanged.
- R9: In flow-through operation, `cs_ni`, `wr_ni` and `xfer_ni` are all held low and `byte_hi_i` is low. Here `code_o` follows the lower bits of `data_i` with one clock of delay, on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; strobes sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, gates the write strobe |
| wr_ni | input | 1 | Write strobe, active low, level sensitive |
| xfer_ni | input | 1 | Transfer strobe, active low, level sensitive |
| byte_hi_i | input | 1 | High: full-word write; low: second-byte write and transfer allowed |
| data_i | input | 10 | Data input; bit 0 is the LSB |
| code_o | output | 10 | DAC register contents driving the converter |
| upd_o | output | 1 | One-cycle pulse when code_o changes |

## Verification
The bench builds the block with its default split: an 8-bit upper section and a 2-bit lower section fed from the top lane of the byte. This matches a left-justified 8-bit bus. With that split, the tests cover two-byte assembly in both orders of write and transfer, and the case where write and transfer coincide. They also check that a transfer is refused while byte-select is high, and follow code-by-code tracking in flow-through operation. The lower-section lane is a parameter. The right-justified lane variant is not built by the bench.

// File: rtl/dac_in_pkg.sv
package dac_in_pkg;

  typedef struct packed {
    logic full_en;   // write of the whole word
    logic lo_en;     // write of the lower section only
    logic xfer_en;   // input latch -> DAC register
  } strobe_t;

endpackage

// File: rtl/dac_strobe_dec.sv
module dac_strobe_dec
  import dac_in_pkg::*;
(
  input  logic    cs_ni,
  input  logic    wr_ni,
  input  logic    xfer_ni,
  input  logic    byte_hi_i,
  output strobe_t st_o
);

  logic wr_en;

  assign wr_en      = ~cs_ni & ~wr_ni;
  assign st_o.full_en = wr_en & byte_hi_i;
  assign st_o.lo_en   = wr_en & ~byte_hi_i;
  // transfer is refused while the full-word select is up
  assign st_o.xfer_en = ~xfer_ni & ~byte_hi_i;

endmodule

// File: rtl/dac_in_latch.sv
module dac_in_latch
  import dac_in_pkg::*;
#(
  parameter int unsigned HI_W        = 8,
  parameter int unsigned LO_W        = 2,
  parameter bit          LO_FROM_TOP = 1'b1,
  localparam int unsigned CODE_W     = HI_W + LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           st_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] in_q_o,
  output logic [CODE_W-1:0] in_next_o
);

  logic [HI_W-1:0] hi_q, hi_next;
  logic [LO_W-1:0] lo_q, lo_next, lo_src;

  generate
    if (LO_FROM_TOP) begin : g_lane_top
      // left-justified byte bus: second byte delivers LSBs in its top bits
      assign lo_src = data_i[CODE_W-1 -: LO_W];
    end else begin : g_lane_bot
      assign lo_src = data_i[LO_W-1:0];
    end
  endgenerate

  always_comb begin
    hi_next = hi_q;
    lo_next = lo_q;
    if (st_i.full_en) begin
      hi_next = data_i[CODE_W-1:LO_W];
      lo_next = data_i[LO_W-1:0];
    end else if (st_i.lo_en) begin
      lo_next = lo_src;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_next;
      lo_q <= lo_next;
    end
  end

  assign in_q_o    = {hi_q, lo_q};
  assign in_next_o = {hi_next, lo_next};

  AST_HI_HOLD_2ND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i.lo_en |=> $stable(hi_q)) else $error("upper section moved on second byte"); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_i.full_en || st_i.lo_en) |=> $stable({hi_q, lo_q})) else $error("latch moved without write"); // R1

endmodule

// File: rtl/dac_code_reg.sv
module dac_code_reg
  import dac_in_pkg::*;
#(
  parameter int unsigned CODE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           st_i,
  input  logic [CODE_W-1:0] in_next_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);

  logic [CODE_W-1:0] code_q;
  logic              upd_q;
  logic              load;

  // in_next carries same-cycle write data, giving auto-transfer and flow-through
  assign load = st_i.xfer_en && (in_next_i != code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= load;
      if (load) code_q <= in_next_i;
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;

  AST_NO_XFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_i.xfer_en |=> $stable(code_q)) else $error("code moved without transfer"); // R5

  AST_UPD_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (code_q != $past(code_q))) else $error("pulse without change"); // R8

  AST_CHANGE_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> upd_q) else $error("change without pulse"); // R8

endmodule

// File: rtl/dac_dbuf_front.sv
module dac_dbuf_front
  import dac_in_pkg::*;
#(
  parameter int unsigned HI_W        = 8,
  parameter int unsigned LO_W        = 2,
  parameter bit          LO_FROM_TOP = 1'b1,
  localparam int unsigned CODE_W     = HI_W + LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              xfer_ni,
  input  logic              byte_hi_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o
);

  strobe_t           st;
  logic [CODE_W-1:0] in_q, in_next;

  dac_strobe_dec u_dec (
    .cs_ni     (cs_ni),
    .wr_ni     (wr_ni),
    .xfer_ni   (xfer_ni),
    .byte_hi_i (byte_hi_i),
    .st_o      (st)
  );

  dac_in_latch #(
    .HI_W        (HI_W),
    .LO_W        (LO_W),
    .LO_FROM_TOP (LO_FROM_TOP)
  ) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_i      (st),
    .data_i    (data_i),
    .in_q_o    (in_q),
    .in_next_o (in_next)
  );

  dac_code_reg #(
    .CODE_W (CODE_W)
  ) u_code (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_i      (st),
    .in_next_i (in_next),
    .code_o    (code_o),
    .upd_o     (upd_o)
  );

  AST_CS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> $stable(in_q)) else $error("write passed with chip deselected"); // R2

  AST_BYTE_HI_NO_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_hi_i |=> !upd_o) else $error("transfer while full-word select high"); // R5

endmodule

// File: tb/dac_dbuf_front_tb.sv
module dac_dbuf_front_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, wr_ni = 1'b1, xfer_ni = 1'b1, byte_hi_i = 1'b1;
  logic [9:0] data_i = '0;
  logic [9:0] code_o;
  logic       upd_o;
  int         checks = 0;
  int         errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf_front u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .cs_ni (cs_ni), .wr_ni (wr_ni),
    .xfer_ni (xfer_ni), .byte_hi_i (byte_hi_i), .data_i (data_i),
    .code_o (code_o), .upd_o (upd_o)
  );

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_ni = 1'b1; wr_ni = 1'b1; xfer_ni = 1'b1; byte_hi_i = 1'b1;
  endtask

  // apply strobes for one clock, return at the following negedge
  task automatic step(logic cs, logic wr, logic xf, logic bh, logic [9:0] d);
    cs_ni = cs; wr_ni = wr; xfer_ni = xf; byte_hi_i = bh; data_i = d;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R7 code after reset", code_o, 10'h000);
    chk("R7 upd after reset", {9'b0, upd_o}, 10'h000);
  endtask

  task automatic t_double();
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'h2D6);           // R3 full word
    data_i = 10'h0F0; @(negedge clk);                // R1 data change ignored
    chk("R5 no transfer yet", code_o, 10'h000);
    step(1'b1, 1'b1, 1'b0, 1'b0, 10'h0F0);
    chk("R3 full word transferred", code_o, 10'h2D6);
    chk("R8 pulse on change", {9'b0, upd_o}, 10'h001);
    @(negedge clk);
    chk("R8 pulse one cycle", {9'b0, upd_o}, 10'h000);
    step(1'b1, 1'b1, 1'b0, 1'b0, 10'h000);
    chk("R8 no pulse same value", {9'b0, upd_o}, 10'h000);
    chk("R1 latch held", code_o, 10'h2D6);
  endtask

  task automatic t_cs_block();
    step(1'b1, 1'b0, 1'b1, 1'b1, 10'h111);
    step(1'b1, 1'b1, 1'b0, 1'b0, 10'h000);
    chk("R2 write ignored when deselected", code_o, 10'h2D6);
    chk("R2 no pulse", {9'b0, upd_o}, 10'h000);
  endtask

  task automatic t_xfer_block();
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'h3FF);
    step(1'b1, 1'b1, 1'b0, 1'b1, 10'h000);
    chk("R5 transfer refused with byte_hi high", code_o, 10'h2D6);
    step(1'b1, 1'b1, 1'b0, 1'b0, 10'h000);
    chk("R5 transfer accepted", code_o, 10'h3FF);
  endtask

  task automatic t_two_byte();
    step(1'b0, 1'b0, 1'b1, 1'b1, {8'h5A, 2'b11});    // first byte, lower bits 11
    step(1'b0, 1'b0, 1'b1, 1'b0, {2'b00, 8'hFF});    // second byte, no transfer
    chk("R5 staged only", code_o, 10'h3FF);
    step(1'b1, 1'b1, 1'b0, 1'b0, 10'h000);
    chk("R4 second byte from top lane", code_o, {8'h5A, 2'b00});
    step(1'b0, 1'b0, 1'b0, 1'b0, {2'b01, 8'h00});    // auto transfer
    chk("R6 auto transfer", code_o, {8'h5A, 2'b01});
    chk("R6 pulse", {9'b0, upd_o}, 10'h001);
  endtask

  task automatic t_flow();
    cs_ni = 1'b0; wr_ni = 1'b0; xfer_ni = 1'b0; byte_hi_i = 1'b0;
    data_i = {2'b11, 8'h00}; @(negedge clk);
    chk("R9 follow 11", code_o, {8'h5A, 2'b11});
    data_i = {2'b10, 8'h00}; @(negedge clk);
    chk("R9 follow 10", code_o, {8'h5A, 2'b10});
    chk("R9 pulse", {9'b0, upd_o}, 10'h001);
    data_i = {2'b10, 8'h33}; @(negedge clk);
    chk("R9 steady no pulse", {9'b0, upd_o}, 10'h000);
    idle();
  endtask

  task automatic t_async_reset();
    #(CLK_PERIOD/4) rst_ni = 1'b0;
    #1;
    chk("R7 async clear", code_o, 10'h000);
    @(negedge clk); rst_ni = 1'b1; @(negedge clk);
    step(1'b1, 1'b1, 1'b0, 1'b0, 10'h000);
    chk("R7 latch cleared", code_o, 10'h000);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_double();
    t_cs_block();
    t_xfer_block();
    t_two_byte();
    t_flow();
    t_async_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule